// File: doc/BRIEF.md
# SECDED Read Decoder with Test Injection

This block sits on the read return path of a memory array protected by a single-error-correct, double-error-detect code with 8 check bits over 64 data bits. Each returned double word is decoded, a single flipped bit is repaired, and a word with two flipped bits is passed through unchanged with an uncorrectable flag. Two sticky status flags, cleared by writing 1, record that a correction or an uncorrectable error was seen. An address register captures the double-word address of the last failing read.

For testing the decoder itself, a check-mode input diverts one tagged address to a pair of injection values (data and check bits) held outside the block. Software writes the tagged address into the same address register. Any read of that address then runs the injected word through the real decoder, and other addresses still use the array. While check mode is on, errors do not load the address register, so the tag survives the very errors it provokes.

Top module: `ecc_chk_path`

## Requirements
- R1: The code places data bit d at the d-th integer (counting from 0) in 3..71 that is not a power of two. Check bit i (i < 7) is the even parity of the data bits whose position has bit i set. Check bit 7 makes the parity of all 72 stored bits even. A read of a valid codeword returns its data with out_ce = 0 and out_ue = 0.
- R2: A read with exactly one flipped bit among the 72 returns the original data with out_ce = 1 and out_ue = 0.
- R3: A read with exactly two flipped bits returns the raw data as read, with out_ue = 1 and out_ce = 0.
- R4: out_valid is high exactly in the cycle after a cycle with rd_valid high, and out_data, out_ce and out_ue belong to that read. out_ce and out_ue are low whenever out_valid is low.
- R5: When check_en is high and rd_addr equals err_addr, the decoder takes inj_data and inj_chk in place of arr_data and arr_chk. Otherwise it takes the array values.
- R6: When check_en is low, a read that is corrected or uncorrectable loads err_addr with its rd_addr, one clock after rd_valid.
- R7: When check_en is high, no read changes err_addr.
- R8: sts_ce and sts_ue are set by a read with out_ce or out_ue and stay set until clr_ce or clr_ue is pulsed. A set in the same cycle as a clear wins.
- R9: tag_wr loads err_addr with tag_wdata on the next clock, with priority over an error capture in the same cycle.
- R10: After reset, out_valid, out_ce, out_ue, sts_ce, sts_ue and err_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_en | input | 1 | Decoder check mode |
| inj_data | input | 64 | Injected data word |
| inj_chk | input | 8 | Injected check bits |
| tag_wr | input | 1 | Write strobe for the address register |
| tag_wdata | input | ADDR_W | Value written into the address register |
| clr_ce | input | 1 | Write-1 clear of sts_ce |
| clr_ue | input | 1 | Write-1 clear of sts_ue |
| rd_valid | input | 1 | Array data returned this cycle |
| rd_addr | input | ADDR_W | Double-word address of the read |
| arr_data | input | 64 | Data bits from the array |
| arr_chk | input | 8 | Check bits from the array |
| out_valid | output | 1 | Decoded read valid |
| out_data | output | 64 | Decoded (corrected or raw) data |
| out_ce | output | 1 | This read was corrected |
| out_ue | output | 1 | This read was uncorrectable |
| sts_ce | output | 1 | Sticky correction flag |
| sts_ue | output | 1 | Sticky uncorrectable flag |
| err_addr | output | ADDR_W | Captured failing address or tagged address |

## Verification
The bench flips single bits in every one of the 72 positions, including check bit 7, whose syndrome is zero. A decoder that ignored it would report a clean read, and one that decoded it as a data position would corrupt a data bit. Pairs that involve check bit 7 must still be reported as uncorrectable, not miscorrected. In check mode it reads both the tagged address and a neighbouring one. A broken address compare would return injected data for the wrong read, and a missing freeze would lose the tag on the first provoked error. It also collides a clear with a new error and a tag write with a capture, where the wrong priority drops a flag or overwrites the tag.

// File: rtl/eccp_pkg.sv
// Shared constants and types for the SECDED read decoder.
// Assumes a 64-bit data word with a 7-bit Hamming syndrome and one overall parity bit.
package eccp_pkg;

    localparam int DW   = 64;
    localparam int SW   = 7;
    localparam int CW   = SW + 1;
    localparam int NPOS = DW + SW;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_CORR   = 2'd1,
        ECC_UNCORR = 2'd2
    } ecc_class_t;

    // Codeword position (3..71) of data bit d: the d-th non-power-of-two.
    function automatic int data_pos(input int d);
        int r;
        int cnt;
        r   = 0;
        cnt = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == d) r = p;
                cnt++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_src_sel.sv
// Chooses the word fed to the decoder: the injected word when check mode is on
// and the read address matches the tagged address, else the array word.
// Assumes all inputs are stable in the cycle rd_valid is high.
module ecc_src_sel #(
    parameter int ADDR_W = 29,
    parameter int DATA_W = eccp_pkg::DW,
    parameter int CHK_W  = eccp_pkg::CW
) (
    input  logic              check_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [CHK_W-1:0]  arr_chk,
    input  logic [DATA_W-1:0] inj_data,
    input  logic [CHK_W-1:0]  inj_chk,
    output logic [DATA_W-1:0] sel_data,
    output logic [CHK_W-1:0]  sel_chk
);

    logic use_inj;

    // Pick the source for this read.
    always_comb begin
        use_inj  = check_en && (rd_addr == tag_addr);
        sel_data = use_inj ? inj_data : arr_data;
        sel_chk  = use_inj ? inj_chk  : arr_chk;
    end

endmodule

// File: rtl/ecc_syndrome.sv
// Recomputes the Hamming check bits over the data, XORs them with the stored
// ones to form the syndrome, and computes the overall parity of the codeword.
// Assumes the position layout of eccp_pkg::data_pos.
module ecc_syndrome #(
    parameter int DATA_W = eccp_pkg::DW,
    parameter int SYN_W  = eccp_pkg::SW,
    localparam int CHK_W = SYN_W + 1
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [SYN_W-1:0]  syn,
    output logic              par
);

    // Data bits that feed syndrome bit i.
    function automatic logic [DATA_W-1:0] cover_mask(input int i);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int d = 0; d < DATA_W; d++) begin
            if (((eccp_pkg::data_pos(d) >> i) & 1) != 0) m[d] = 1'b1;
        end
        return m;
    endfunction

    for (genvar i = 0; i < SYN_W; i++) begin : g_syn
        localparam logic [DATA_W-1:0] MASK = cover_mask(i);
        // One syndrome bit: stored check bit against recomputed parity.
        always_comb syn[i] = chk[i] ^ (^(data & MASK));
    end

    // Overall parity over all stored bits.
    always_comb par = (^data) ^ (^chk);

endmodule

// File: rtl/ecc_fix.sv
// Classifies a decoded word from syndrome and parity and flips the data bit
// a single error points at. Double or out-of-range errors leave data raw.
module ecc_fix #(
    parameter int DATA_W = eccp_pkg::DW,
    parameter int SYN_W  = eccp_pkg::SW,
    localparam int NPOS  = DATA_W + SYN_W
) (
    input  logic [DATA_W-1:0]     data,
    input  logic [SYN_W-1:0]      syn,
    input  logic                  par,
    output logic [DATA_W-1:0]     fixed,
    output eccp_pkg::ecc_class_t  cls
);

    logic single;
    logic in_range;

    // Single-error indication and syndrome range test.
    always_comb begin
        in_range = (int'(syn) <= NPOS);
        single   = par && in_range;
    end

    for (genvar d = 0; d < DATA_W; d++) begin : g_fix
        localparam logic [SYN_W-1:0] POS = SYN_W'(eccp_pkg::data_pos(d));
        // Flip this bit when a single error points at its position.
        always_comb fixed[d] = data[d] ^ (single && (syn == POS));
    end

    // Error class of the read.
    always_comb begin
        if (!par && (syn == '0))  cls = eccp_pkg::ECC_CLEAN;
        else if (single)          cls = eccp_pkg::ECC_CORR;
        else                      cls = eccp_pkg::ECC_UNCORR;
    end

endmodule

// File: rtl/ecc_chk_path.sv
// SECDED read decoder with test injection. One register stage: results,
// sticky flags and the address register update on the clock after rd_valid.
// Assumes at most one read per cycle and that software drives tag_wr and the
// clear strobes as single-cycle pulses.
module ecc_chk_path #(
    parameter int ADDR_W = 29,
    parameter int DATA_W = eccp_pkg::DW,
    parameter int SYN_W  = eccp_pkg::SW,
    localparam int CHK_W = SYN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en,
    input  logic [DATA_W-1:0] inj_data,
    input  logic [CHK_W-1:0]  inj_chk,
    input  logic              tag_wr,
    input  logic [ADDR_W-1:0] tag_wdata,
    input  logic              clr_ce,
    input  logic              clr_ue,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [CHK_W-1:0]  arr_chk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ce,
    output logic              out_ue,
    output logic              sts_ce,
    output logic              sts_ue,
    output logic [ADDR_W-1:0] err_addr
);

    logic [DATA_W-1:0]    sel_data;
    logic [CHK_W-1:0]     sel_chk;
    logic [SYN_W-1:0]     syn;
    logic                 par;
    logic [DATA_W-1:0]    fixed;
    eccp_pkg::ecc_class_t cls;
    logic                 hit_ce;
    logic                 hit_ue;

    ecc_src_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_sel (
        .check_en (check_en),
        .rd_addr  (rd_addr),
        .tag_addr (err_addr),
        .arr_data (arr_data),
        .arr_chk  (arr_chk),
        .inj_data (inj_data),
        .inj_chk  (inj_chk),
        .sel_data (sel_data),
        .sel_chk  (sel_chk)
    );

    ecc_syndrome #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_syn (
        .data (sel_data),
        .chk  (sel_chk),
        .syn  (syn),
        .par  (par)
    );

    ecc_fix #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_fix (
        .data  (sel_data),
        .syn   (syn),
        .par   (par),
        .fixed (fixed),
        .cls   (cls)
    );

    // Qualify the error class with the read strobe.
    always_comb begin
        hit_ce = rd_valid && (cls == eccp_pkg::ECC_CORR);
        hit_ue = rd_valid && (cls == eccp_pkg::ECC_UNCORR);
    end

    // Register the decoded result of each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ce    <= 1'b0;
            out_ue    <= 1'b0;
        end else begin
            out_valid <= rd_valid;
            out_ce    <= hit_ce;
            out_ue    <= hit_ue;
            if (rd_valid) out_data <= fixed;
        end
    end

    // Sticky flags: a new event wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_ce <= 1'b0;
            sts_ue <= 1'b0;
        end else begin
            sts_ce <= (sts_ce && !clr_ce) || hit_ce;
            sts_ue <= (sts_ue && !clr_ue) || hit_ue;
        end
    end

    // Address register: software write first, error capture outside check mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
        end else if (tag_wr) begin
            err_addr <= tag_wdata;
        end else if (!check_en && (hit_ce || hit_ue)) begin
            err_addr <= rd_addr;
        end
    end

endmodule

// File: rtl/ecc_chk_path_sva.sv
// Property checker for ecc_chk_path, attached with bind below.
module ecc_chk_path_sva #(
    parameter int ADDR_W = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              check_en,
    input logic              tag_wr,
    input logic [ADDR_W-1:0] tag_wdata,
    input logic              clr_ce,
    input logic              clr_ue,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              out_valid,
    input logic              out_ce,
    input logic              out_ue,
    input logic              sts_ce,
    input logic              sts_ue,
    input logic [ADDR_W-1:0] err_addr
);

    // R4: result valid exactly one clock after the read strobe
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);
    a_r4_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);
    // R4: flags only travel with a valid result
    a_r4_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ce || out_ue) |-> out_valid);
    // R2 / R3: a read is never both corrected and uncorrectable
    a_r2_ce_ue_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ce && out_ue));
    // R8: flagged read shows in the sticky flags
    a_r8_ce_sets: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |-> sts_ce);
    a_r8_ue_sets: assert property (@(posedge clk) disable iff (!rst_n)
        out_ue |-> sts_ue);
    // R8: sticky flags hold without a clear
    a_r8_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ce && !clr_ce) |=> sts_ce);
    a_r8_ue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ue && !clr_ue) |=> sts_ue);
    // R7: check mode freezes the address register
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && !tag_wr) |=> $stable(err_addr));
    // R6: failing read outside check mode is captured
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !check_en && !tag_wr) |=>
            (!(out_ce || out_ue) || (err_addr == $past(rd_addr))));
    // R9: software write lands in the address register
    a_r9_tag_write: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr |=> (err_addr == $past(tag_wdata)));

endmodule

bind ecc_chk_path ecc_chk_path_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .check_en  (check_en),
    .tag_wr    (tag_wr),
    .tag_wdata (tag_wdata),
    .clr_ce    (clr_ce),
    .clr_ue    (clr_ue),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_ce    (out_ce),
    .out_ue    (out_ue),
    .sts_ce    (sts_ce),
    .sts_ue    (sts_ue),
    .err_addr  (err_addr)
);

// File: tb/ecc_chk_path_test.sv
`timescale 1ns/1ps
module ecc_chk_path_test;

    localparam int AW = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          check_en = 1'b0;
    logic [63:0]   inj_data = '0;
    logic [7:0]    inj_chk = '0;
    logic          tag_wr = 1'b0;
    logic [AW-1:0] tag_wdata = '0;
    logic          clr_ce = 1'b0;
    logic          clr_ue = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   arr_data = '0;
    logic [7:0]    arr_chk = '0;
    logic          out_valid;
    logic [63:0]   out_data;
    logic          out_ce;
    logic          out_ue;
    logic          sts_ce;
    logic          sts_ue;
    logic [AW-1:0] err_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_addr = '0;
    logic          m_sce  = 1'b0;
    logic          m_sue  = 1'b0;

    ecc_chk_path #(.ADDR_W(AW)) uut (.*);

    always #4 clk = ~clk;

    // Encoder written from the code definition in R1.
    function automatic logic [7:0] enc(input logic [63:0] d);
        logic [127:0] cw;
        logic [7:0]   c;
        int           k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < 7; i++) begin
            c[i] = 1'b0;
            for (int p = 1; p <= 71; p++) if (((p >> i) & 1) != 0) c[i] ^= cw[p];
        end
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    // Nearest-codeword decode by brute force over all single flips.
    function automatic void ref_dec(input logic [71:0] w, output logic [63:0] d,
                                    output logic ce, output logic ue);
        logic [71:0] t;
        d  = w[63:0];
        ce = 1'b0;
        ue = 1'b0;
        if (enc(w[63:0]) != w[71:64]) begin
            ue = 1'b1;
            for (int b = 0; b < 72; b++) begin
                t = w;
                t[b] = ~t[b];
                if (ue && enc(t[63:0]) == t[71:64]) begin
                    d  = t[63:0];
                    ce = 1'b1;
                    ue = 1'b0;
                end
            end
        end
    endfunction

    // Flip n distinct random bits of a 72-bit word.
    function automatic logic [71:0] corrupt(input logic [71:0] w, input int n);
        int a;
        int b;
        a = $urandom_range(71);
        b = (a + 1 + $urandom_range(70)) % 72;
        if (n >= 1) w[a] = ~w[a];
        if (n >= 2) w[b] = ~w[b];
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " sts_ce"}, 64'(sts_ce), 64'(m_sce));
        check({req, " sts_ue"}, 64'(sts_ue), 64'(m_sue));
        check({req, " err_addr"}, 64'(err_addr), 64'(m_addr));
    endtask

    // One read of a raw 72-bit array word; optional clears in the same cycle.
    task automatic do_read(input string req, input logic [AW-1:0] a, input logic [71:0] w,
                           input bit clr);
        logic [71:0] src;
        logic [63:0] ed;
        logic        ece;
        logic        eue;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = a;
        arr_data = w[63:0];
        arr_chk  = w[71:64];
        clr_ce   = clr;
        clr_ue   = clr;
        src = (check_en && a == m_addr) ? {inj_chk, inj_data} : w;
        ref_dec(src, ed, ece, eue);
        m_sce = (m_sce && !clr) || ece;
        m_sue = (m_sue && !clr) || eue;
        if (!check_en && (ece || eue)) m_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        clr_ce   = 1'b0;
        clr_ue   = 1'b0;
        check({req, " out_valid"}, 64'(out_valid), 64'd1);
        check({req, " out_data"}, out_data, ed);
        check({req, " out_ce"}, 64'(out_ce), 64'(ece));
        check({req, " out_ue"}, 64'(out_ue), 64'(eue));
        check_state(req);
    endtask

    task automatic write_tag(input logic [AW-1:0] v);
        @(negedge clk);
        tag_wr    = 1'b1;
        tag_wdata = v;
        m_addr    = v;
        @(negedge clk);
        tag_wr = 1'b0;
        check_state("R9 tag write");
    endtask

    task automatic clear_flags;
        @(negedge clk);
        clr_ce = 1'b1;
        clr_ue = 1'b1;
        m_sce  = 1'b0;
        m_sue  = 1'b0;
        @(negedge clk);
        clr_ce = 1'b0;
        clr_ue = 1'b0;
        check_state("R8 clear");
        check("R4 idle out_valid", 64'(out_valid), 64'd0);
    endtask

    function automatic logic [71:0] cw_of(input logic [63:0] d);
        return {enc(d), d};
    endfunction

    initial begin
        logic [63:0]   d;
        logic [AW-1:0] a;
        logic [71:0]   w;
        void'($urandom(32'h5EC0DE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 out_ce", 64'(out_ce), 64'd0);
        check("R10 out_ue", 64'(out_ue), 64'd0);
        check_state("R10 reset");

        // R1 clean reads, including all-zero and all-one data
        do_read("R1 clean zero", 29'h10, cw_of(64'h0), 1'b0);
        do_read("R1 clean ones", 29'h11, cw_of('1), 1'b0);
        do_read("R1 clean pattern", 29'h12, cw_of(64'hDEAD_BEEF_0123_4567), 1'b0);

        // R2 every single-bit position, R6 capture of each failing address
        for (int b = 0; b < 72; b++) begin
            w = cw_of(64'hA5A5_5A5A_F00F_0FF0);
            w[b] = ~w[b];
            do_read("R2 R6 single flip", AW'(b + 100), w, 1'b0);
        end
        // R3 pairs with overall-parity bit and within data
        w = cw_of(64'h1234); w[71] = ~w[71]; w[0] = ~w[0];
        do_read("R3 double with top check", 29'h200, w, 1'b0);
        w = cw_of(64'h1234); w[5] = ~w[5]; w[63] = ~w[63];
        do_read("R3 double data", 29'h201, w, 1'b0);

        // R8 clear, then a set colliding with a clear
        clear_flags();
        w = cw_of(64'h77); w[3] = ~w[3];
        do_read("R8 set wins over clear", 29'h300, w, 1'b1);
        clear_flags();

        // R9 tag write colliding with an error capture
        @(negedge clk);
        w = cw_of(64'h99); w[7] = ~w[7];
        rd_valid = 1'b1; rd_addr = 29'h444; arr_data = w[63:0]; arr_chk = w[71:64];
        tag_wr = 1'b1; tag_wdata = 29'h0ABC;
        m_addr = 29'h0ABC; m_sce = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0; tag_wr = 1'b0;
        check_state("R9 write wins over capture");
        clear_flags();

        // R5 R7 check mode: injected double error at the tag, clean array
        check_en = 1'b1;
        inj_data = 64'hCAFE_F00D_0000_FFFF;
        w = cw_of(inj_data); w[10] = ~w[10]; w[40] = ~w[40];
        inj_data = w[63:0]; inj_chk = w[71:64];
        do_read("R5 R7 inject double", 29'h0ABC, cw_of(64'h5555), 1'b0);
        do_read("R5 neighbour uses array", 29'h0ABD, cw_of(64'h6666), 1'b0);
        w = cw_of(64'hCAFE_F00D_0000_FFFF); w[68] = ~w[68];
        inj_data = w[63:0]; inj_chk = w[71:64];
        do_read("R5 R7 inject single", 29'h0ABC, cw_of(64'h5555), 1'b0);
        w = cw_of(64'h1); w[2] = ~w[2];
        do_read("R7 array error in check mode", 29'h0123, w, 1'b0);
        check_en = 1'b0;
        do_read("R5 mode off uses array", 29'h0ABC, cw_of(64'h5555), 1'b0);
        clear_flags();

        // Random mix across all requirements
        for (int it = 0; it < 800; it++) begin
            d = {$urandom, $urandom};
            w = corrupt(cw_of(d), $urandom_range(2));
            a = ($urandom_range(3) == 0) ? m_addr : AW'($urandom);
            if ($urandom_range(15) == 0) check_en = ~check_en;
            if ($urandom_range(31) == 0) write_tag(AW'($urandom));
            if (check_en) begin
                logic [71:0] iw;
                iw = corrupt(cw_of({$urandom, $urandom}), $urandom_range(2));
                inj_data = iw[63:0];
                inj_chk  = iw[71:64];
            end
            do_read("R1 R2 R3 R5 R6 R7 R8 random", a, w, $urandom_range(7) == 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule